// File: doc/BRIEF.md
# ALU Dependency Delay Issue Gate

This block sits in an in-order issue stage. Each cycle it sees at most one instruction. Most instructions simply pass when the downstream stage is ready. A delay-hint instruction passes at once. Its operand names two waits: the first applies to the instruction right after the hint, and the second applies to an instruction placed by a skip distance. The gate then holds `issue_en` low for each targeted instruction until the named condition is met.

A wait can be of two kinds. The first kind refers to an earlier vector or transcendental instruction, counted back in issue order. It is tracked in a four-entry history of those issues, and each entry is marked complete by the matching completion pulse. The second kind is a fixed penalty of one to three cycles, counted from the cycle the targeted instruction first shows up at issue.

Top module: `alu_delay_gate`

## Requirements
- R1: The operand fields are: bits 3:0 hold the first wait ID, bits 6:4 hold the skip distance, and bits 10:7 hold the second wait ID.
- R2: A hint issues in any cycle where it is valid and `ready` is high. It takes no history slot, and it is not counted as one of the instructions the skip distance passes over.
- R3: ID 0 and IDs 12 to 15 mean no wait. A hint whose two IDs both mean no wait stalls nothing.
- R4: IDs 1 to 4 hold the target until the vector or transcendental issue that many places back in the history is complete.
- R5: IDs 5 to 7 hold the target until the history entry 1, 2 or 3 places back (ID minus 4) is complete.
- R6: A pulse on `vec_done` marks the oldest incomplete vector entry complete, and a pulse on `trans_done` does the same for the oldest incomplete transcendental entry. A pulse that finds no such entry is ignored.
- R7: ID 8 is a 1-cycle penalty, and IDs 9, 10 and 11 are penalties of 1, 2 and 3 cycles. An instruction first presented in cycle t may issue no earlier than t+penalty. The count runs even while `ready` is low.
- R8: With skip value s, the second wait lands on the (s+1)-th non-hint instruction after the hint. Values 6 and 7 act as 5.
- R9: When both waits land on the same instruction, it issues only once both are satisfied.
- R10: A hint that issues while earlier waits are still pending replaces them.
- R11: `issue_en` is high only when `in_valid` and `ready` are both high.
- R12: After reset no wait is pending and every history entry counts as complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented at issue |
| in_is_hint | input | 1 | The presented instruction is a delay hint |
| in_cls | input | 2 | Class of a non-hint instruction: 0 other, 1 vector, 2 transcendental |
| in_operand | input | 11 | Hint operand, bits 10:0 |
| vec_done | input | 1 | Vector result completion pulse |
| trans_done | input | 1 | Transcendental result completion pulse |
| ready | input | 1 | Downstream can accept an instruction |
| issue_en | output | 1 | The presented instruction issues this cycle |

## Verification
The assertions assume that a presented instruction holds `in_valid` and its fields steady until it issues. They also assume that completion pulses arrive in issue order per type, with no more than four vector and transcendental results outstanding, so that no incomplete entry is pushed out of the history. The stimulus presents each instruction until the gate takes it, drops `in_valid` for one cycle between instructions, and sends each completion pulse only for an instruction still held in the history. The one exception is a deliberate stray pulse sent while nothing is outstanding.

// File: rtl/alu_dly_pkg.sv
package alu_dly_pkg;

  localparam int ID_W   = 4;
  localparam int SKIP_W = 3;
  localparam int OP_W   = 2 * ID_W + SKIP_W;
  localparam int BACK_W = 3;
  localparam int PEN_W  = 2;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_VEC   = 2'd1,
    CLS_TRANS = 2'd2
  } alu_cls_e;

  typedef struct packed {
    logic              ring;
    logic [BACK_W-1:0] back;
    logic [PEN_W-1:0]  pen;
  } dep_t;

  function automatic dep_t dep_decode(input logic [ID_W-1:0] id);
    dep_t d;
    d = '0;
    case (id)
      4'd1, 4'd2, 4'd3, 4'd4: begin
        d.ring = 1'b1;
        d.back = id[BACK_W-1:0];
      end
      4'd5, 4'd6, 4'd7: begin
        d.ring = 1'b1;
        d.back = BACK_W'(id - 4'd4);
      end
      4'd8, 4'd9: d.pen  = 2'd1;
      4'd10:      d.pen  = 2'd2;
      4'd11:      d.pen  = 2'd3;
      default:    d      = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dly_hist_ring.sv
module dly_hist_ring
  import alu_dly_pkg::*;
#(
  parameter int HIST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  alu_cls_e        push_cls,
  input  logic            vec_done,
  input  logic            trans_done,
  output logic [HIST-1:0] done_o
);

  localparam int IDX_W = $clog2(HIST);

  alu_cls_e          cls_q [HIST];
  alu_cls_e          cls_d [HIST];
  logic [HIST-1:0]   done_q, done_d, marked;
  logic [IDX_W-1:0]  vsel, tsel;
  logic              vhit, thit;

  // Oldest incomplete entry of each type: the highest index wins.
  always_comb begin
    vhit = 1'b0;
    thit = 1'b0;
    vsel = '0;
    tsel = '0;
    for (int i = 0; i < HIST; i++) begin
      if (!done_q[i] && cls_q[i] == CLS_VEC) begin
        vhit = 1'b1;
        vsel = IDX_W'(i);
      end
      if (!done_q[i] && cls_q[i] == CLS_TRANS) begin
        thit = 1'b1;
        tsel = IDX_W'(i);
      end
    end
    marked = done_q;
    if (vec_done && vhit)   marked[vsel] = 1'b1;
    if (trans_done && thit) marked[tsel] = 1'b1;
  end

  // Entry 0 is the most recent issue; a push shifts everything one place older.
  for (genvar g = 0; g < HIST; g++) begin : g_slot
    if (g == 0) begin : g_head
      assign cls_d[g]  = push ? push_cls : cls_q[g];
      assign done_d[g] = push ? 1'b0     : marked[g];
    end else begin : g_body
      assign cls_d[g]  = push ? cls_q[g-1]  : cls_q[g];
      assign done_d[g] = push ? marked[g-1] : marked[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) cls_q[i] <= CLS_NONE;
      done_q <= '1;
    end else begin
      for (int i = 0; i < HIST; i++) cls_q[i] <= cls_d[i];
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/dly_target_track.sv
module dly_target_track
  import alu_dly_pkg::*;
#(
  parameter int MAX_SKIP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hint_go,
  input  logic [ID_W-1:0]   op_id0,
  input  logic [SKIP_W-1:0] op_skip,
  input  logic [ID_W-1:0]   op_id1,
  input  logic              inst_go,
  output logic [ID_W-1:0]   act0,
  output logic [ID_W-1:0]   act1
);

  localparam int DIST_W = SKIP_W + 1;

  logic              a_arm_q, a_arm_d;
  logic [ID_W-1:0]   a_id_q,  a_id_d;
  logic              b_arm_q, b_arm_d;
  logic [ID_W-1:0]   b_id_q,  b_id_d;
  logic [DIST_W-1:0] b_dist_q, b_dist_d;
  logic [SKIP_W-1:0] skip_eff;

  assign skip_eff = (op_skip > SKIP_W'(MAX_SKIP)) ? SKIP_W'(MAX_SKIP) : op_skip;

  assign act0 = a_arm_q ? a_id_q : '0;
  assign act1 = (b_arm_q && b_dist_q == DIST_W'(1)) ? b_id_q : '0;

  always_comb begin
    a_arm_d  = a_arm_q;
    a_id_d   = a_id_q;
    b_arm_d  = b_arm_q;
    b_id_d   = b_id_q;
    b_dist_d = b_dist_q;
    if (hint_go) begin
      a_arm_d  = 1'b1;
      a_id_d   = op_id0;
      b_arm_d  = 1'b1;
      b_id_d   = op_id1;
      b_dist_d = DIST_W'(skip_eff) + DIST_W'(1);
    end else if (inst_go) begin
      a_arm_d = 1'b0;
      if (b_arm_q) begin
        if (b_dist_q == DIST_W'(1)) b_arm_d  = 1'b0;
        else                        b_dist_d = b_dist_q - DIST_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_arm_q  <= 1'b0;
      a_id_q   <= '0;
      b_arm_q  <= 1'b0;
      b_id_q   <= '0;
      b_dist_q <= '0;
    end else begin
      a_arm_q  <= a_arm_d;
      a_id_q   <= a_id_d;
      b_arm_q  <= b_arm_d;
      b_id_q   <= b_id_d;
      b_dist_q <= b_dist_d;
    end
  end

endmodule

// File: rtl/dly_penalty.sv
module dly_penalty
  import alu_dly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             target,
  input  logic [PEN_W-1:0] need,
  input  logic             issue,
  output logic             busy,
  output logic [PEN_W-1:0] cnt
);

  logic [PEN_W-1:0] cnt_q, cnt_d;
  logic             loaded_q, loaded_d;

  assign busy = loaded_q ? (cnt_q != '0) : (target && need != '0);
  assign cnt  = cnt_q;

  always_comb begin
    cnt_d    = cnt_q;
    loaded_d = loaded_q;
    if (issue) begin
      cnt_d    = '0;
      loaded_d = 1'b0;
    end else if (!loaded_q && target && need != '0) begin
      cnt_d    = need - PEN_W'(1);
      loaded_d = 1'b1;
    end else if (loaded_q && cnt_q != '0) begin
      cnt_d    = cnt_q - PEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      loaded_q <= loaded_d;
    end
  end

endmodule

// File: rtl/alu_delay_gate.sv
module alu_delay_gate
  import alu_dly_pkg::*;
#(
  parameter int HIST     = 4,
  parameter int MAX_SKIP = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_is_hint,
  input  logic [1:0]      in_cls,
  input  logic [OP_W-1:0] in_operand,
  input  logic            vec_done,
  input  logic            trans_done,
  input  logic            ready,
  output logic            issue_en
);

  localparam int PAD = 1 << BACK_W;

  logic [HIST-1:0]  hist_done;
  logic [PAD-1:0]   done_pad;
  logic [ID_W-1:0]  act0, act1;
  dep_t             dep0, dep1;
  logic             ring_block, pen_busy;
  logic [PEN_W-1:0] pen_need, pen_cnt;
  logic             hint_go, inst_go, push;
  alu_cls_e         cls;

  assign cls      = alu_cls_e'(in_cls);
  assign done_pad = {{(PAD-HIST){1'b1}}, hist_done};

  assign dep0 = dep_decode(act0);
  assign dep1 = dep_decode(act1);

  assign ring_block = (dep0.ring && !done_pad[dep0.back - BACK_W'(1)]) ||
                      (dep1.ring && !done_pad[dep1.back - BACK_W'(1)]);
  assign pen_need   = (dep0.pen > dep1.pen) ? dep0.pen : dep1.pen;

  assign issue_en = in_valid && ready && (in_is_hint || !(ring_block || pen_busy));
  assign hint_go  = issue_en && in_is_hint;
  assign inst_go  = issue_en && !in_is_hint;
  assign push     = inst_go && (cls == CLS_VEC || cls == CLS_TRANS);

  dly_hist_ring #(.HIST(HIST)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_cls   (cls),
    .vec_done   (vec_done),
    .trans_done (trans_done),
    .done_o     (hist_done)
  );

  dly_target_track #(.MAX_SKIP(MAX_SKIP)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .hint_go (hint_go),
    .op_id0  (in_operand[ID_W-1:0]),
    .op_skip (in_operand[ID_W+SKIP_W-1:ID_W]),
    .op_id1  (in_operand[OP_W-1:ID_W+SKIP_W]),
    .inst_go (inst_go),
    .act0    (act0),
    .act1    (act1)
  );

  dly_penalty u_pen (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (in_valid && !in_is_hint),
    .need   (pen_need),
    .issue  (inst_go),
    .busy   (pen_busy),
    .cnt    (pen_cnt)
  );

endmodule

// File: rtl/alu_delay_gate_chk.sv
module alu_delay_gate_chk
  import alu_dly_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_is_hint,
  input logic             ready,
  input logic             issue_en,
  input logic             ring_block,
  input logic             pen_busy,
  input logic [PEN_W-1:0] pen_cnt,
  input logic [ID_W-1:0]  act0,
  input logic [ID_W-1:0]  act1
);

  a_r11_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |-> (in_valid && ready));

  a_r2_hint_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_hint && ready) |-> issue_en);

  a_r4_ring_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_hint && ring_block) |-> !issue_en);

  a_r7_penalty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_hint && pen_busy) |-> !issue_en);

  a_r7_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_cnt != '0) |=> (pen_cnt == $past(pen_cnt) - PEN_W'(1)));

  a_r3_no_wait_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_hint && ready &&
     dep_decode(act0) == '0 && dep_decode(act1) == '0) |-> issue_en);

endmodule

bind alu_delay_gate alu_delay_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_is_hint (in_is_hint),
  .ready      (ready),
  .issue_en   (issue_en),
  .ring_block (ring_block),
  .pen_busy   (pen_busy),
  .pen_cnt    (pen_cnt),
  .act0       (act0),
  .act1       (act1)
);

// File: tb/alu_delay_gate_bench.sv
`timescale 1ns/1ps
module alu_delay_gate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_is_hint = 1'b0;
  logic [1:0]  in_cls = 2'd0;
  logic [10:0] in_operand = '0;
  logic        vec_done = 1'b0;
  logic        trans_done = 1'b0;
  logic        ready = 1'b1;
  logic        issue_en;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int cur_tag = 0;
  int pres_cyc = 0;

  typedef struct {
    int    tag;
    int    dly;
    string req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alu_delay_gate u_alu_delay_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_hint(in_is_hint),
    .in_cls(in_cls), .in_operand(in_operand), .vec_done(vec_done),
    .trans_done(trans_done), .ready(ready), .issue_en(issue_en)
  );

  // Operand: id0 in bits 3:0, skip in bits 6:4, id1 in bits 10:7 (R1).
  function automatic logic [10:0] mk(input int id0, input int sk, input int id1);
    return {4'(id1), 3'(sk), 4'(id0)};
  endfunction

  // Monitor: pops the expected item on each issue and compares the delay.
  always @(negedge clk) begin
    if (rst_n && issue_en) begin
      compared++;
      if (sb.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected issue: actual tag %0d, expected none (R11)", cur_tag);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.tag != cur_tag || (cyc - pres_cyc) != it.dly) begin
          mismatched++;
          $display("FAIL %s tag %0d: actual delay %0d, expected %0d",
                   it.req, it.tag, cyc - pres_cyc, it.dly);
        end
      end
    end
  end

  task automatic present(input int tag, input bit hint, input int cls,
                         input logic [10:0] op, input int exp, input int pk,
                         input int pat, input int rlo, input string req);
    item_t it;
    bit    got;
    int    waited;
    it.tag = tag; it.dly = exp; it.req = req;
    sb.push_back(it);
    @(posedge clk); #1;
    in_valid = 1'b1; in_is_hint = hint; in_cls = 2'(cls); in_operand = op;
    cur_tag = tag; pres_cyc = cyc;
    if (rlo > 0) ready = 1'b0;
    fork
      begin
        if (rlo > 0) begin
          repeat (rlo) @(posedge clk);
          #1 ready = 1'b1;
        end
      end
      begin
        if (pk != 0) begin
          repeat (pat) @(posedge clk);
          #1;
          if (pk == 1) vec_done = 1'b1; else trans_done = 1'b1;
          @(posedge clk); #1;
          vec_done = 1'b0; trans_done = 1'b0;
        end
      end
    join_none
    got = 1'b0; waited = 0;
    while (!got && waited < 300) begin
      @(negedge clk);
      if (issue_en) got = 1'b1;
      waited++;
    end
    if (!got) begin
      compared++; mismatched++;
      $display("FAIL %s tag %0d: actual no issue, expected delay %0d", req, tag, exp);
      void'(sb.pop_front());
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic ins(input int tag, input int cls, input int exp, input string req);
    present(tag, 1'b0, cls, '0, exp, 0, 0, 0, req);
  endtask

  task automatic hnt(input int tag, input logic [10:0] op, input string req);
    present(tag, 1'b1, 0, op, 0, 0, 0, 0, req);
  endtask

  task automatic lone_pulse(input bit is_vec);
    @(posedge clk); #1;
    if (is_vec) vec_done = 1'b1; else trans_done = 1'b1;
    @(posedge clk); #1;
    vec_done = 1'b0; trans_done = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung run, expected completion (all)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (issue_en !== 1'b0) begin
      mismatched++;
      $display("FAIL R12 reset: actual issue_en %b, expected 0", issue_en);
    end
    ins(1, 0, 0, "R12");
    lone_pulse(1'b1);                                 // R6 stray pulse, nothing outstanding
    ins(2, 1, 0, "R12");                              // vector Va, incomplete
    hnt(3, mk(1, 0, 0), "R2");
    present(4, 1'b0, 0, '0, 3, 1, 2, 0, "R4/R6");     // R4 waits on Va, pulse at +2
    ins(5, 1, 0, "R4");                               // Vb
    ins(6, 1, 0, "R4");                               // Vc
    hnt(7, mk(2, 0, 0), "R1");
    present(8, 1'b0, 0, '0, 2, 1, 1, 0, "R6");        // R6 oldest (Vb) completes
    hnt(9, mk(1, 0, 0), "R4");
    present(10, 1'b0, 0, '0, 1, 1, 0, 0, "R4");       // Vc
    ins(11, 1, 0, "R3");                              // Vd incomplete
    hnt(12, mk(0, 0, 0), "R3");
    ins(13, 0, 0, "R3");
    hnt(14, mk(13, 0, 14), "R3");
    ins(15, 0, 0, "R3");
    lone_pulse(1'b1);
    ins(16, 2, 0, "R5");                              // Ta
    ins(17, 1, 0, "R5");                              // Ve
    hnt(18, mk(6, 0, 0), "R5");
    present(19, 1'b0, 0, '0, 2, 2, 1, 0, "R5");       // R5 two back is Ta
    lone_pulse(1'b1);
    hnt(20, mk(11, 0, 0), "R7");
    ins(21, 0, 3, "R7");
    hnt(22, mk(9, 0, 0), "R7");
    ins(23, 0, 1, "R7");
    hnt(24, mk(10, 0, 0), "R7");
    ins(25, 0, 2, "R7");
    hnt(26, mk(8, 0, 0), "R7");
    ins(27, 0, 1, "R7");
    hnt(28, mk(0, 2, 10), "R8");
    ins(29, 0, 0, "R8");
    ins(30, 0, 0, "R8");
    ins(31, 0, 2, "R8");
    hnt(32, mk(0, 1, 9), "R8");
    ins(33, 0, 0, "R8");
    ins(34, 0, 1, "R8");
    hnt(35, mk(9, 0, 11), "R9");
    ins(36, 0, 3, "R9");
    ins(37, 1, 0, "R9");                              // Vf
    hnt(38, mk(1, 0, 9), "R9");
    present(39, 1'b0, 0, '0, 3, 1, 2, 0, "R9");
    hnt(41, mk(0, 7, 9), "R8");
    for (int i = 0; i < 5; i++) ins(42 + i, 0, 0, "R8");
    ins(47, 0, 1, "R8");
    hnt(48, mk(0, 5, 11), "R10");
    ins(49, 0, 0, "R10");
    ins(50, 0, 0, "R10");
    hnt(51, mk(0, 0, 0), "R10");
    for (int i = 0; i < 6; i++) ins(52 + i, 0, 0, "R10");
    hnt(58, mk(11, 0, 0), "R7");
    present(59, 1'b0, 0, '0, 5, 0, 0, 5, "R11");
    hnt(60, mk(11, 0, 0), "R7");
    present(61, 1'b0, 0, '0, 3, 0, 0, 1, "R7");
    present(62, 1'b1, 0, mk(0, 0, 0), 2, 0, 0, 2, "R11");
    ins(63, 1, 0, "R2");                              // Vg
    hnt(64, mk(0, 0, 0), "R2");
    hnt(65, mk(1, 0, 0), "R2");
    present(66, 1'b0, 0, '0, 1, 1, 0, 0, "R2");       // R2 hints took no slot
    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R11 leftover: actual %0d items, expected 0", sb.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule